// File: doc/BRIEF.md
# Wide Vector Permute Unit

This block sits between the vector memories and the SIMD compute array and reshapes wide byte vectors on their way to the compute lanes. It keeps a small file of full-width byte-vector registers. In any cycle with a valid request, it takes one source vector and passes it through a fixed chain of three operation slots. The source is either the incoming memory vector or one of the registers. Each slot can rotate the vector, broadcast one of its bytes, compress byte groups by signed maximum for pooling, exchange neighbouring bytes, or blend with a register under a byte mask held in another register.

The chain result is captured in an output register, so the operand appears one cycle after the request. In the same cycle the result can also be written back into any register. The vector width, the register count and the rotation limit are parameters. The default width is 128 bytes.

Top module: `vperm_unit`

## Requirements
- R1: While reset is asserted and after its release, `res_valid` is 0, `res_vec` is all zero and every register holds all zero bytes.
- R2: A request with `req_valid`=1 produces its chain result on `res_vec` with `res_valid`=1 in the following cycle. A cycle with `req_valid`=0 drives `res_valid` to 0 in the following cycle and leaves `res_vec` unchanged.
- R3: Slot opcode 1 (rotate) gives output byte i = input byte (i + a) mod NBYTES. Here a is `rot_amt`, limited to MAXROT (64): any larger amount acts as 64.
- R4: Slot opcode 2 (broadcast) copies input byte `bcast_idx` into every output byte.
- R5: Slot opcode 3 (pair pool) sets output byte j, for j < NBYTES/2, to the signed maximum of input bytes 2j and 2j+1. All higher bytes are zero.
- R6: Slot opcode 4 (quad pool) sets output byte j, for j < NBYTES/4, to the signed maximum of input bytes 4j..4j+3. All higher bytes are zero.
- R7: Slot opcode 5 (swap) exchanges bytes 2k and 2k+1 for every k.
- R8: Slot opcode 6 (merge) gives output byte i = byte i of register `blend_sel` when bit 0 of byte i of register `mask_sel` is 1. Otherwise it keeps input byte i.
- R9: The three slots apply in the order `op_a`, `op_b`, `op_c`, each on the previous slot's output. Opcodes 0 and 7 pass the vector through unchanged.
- R10: The chain source is `mem_vec` when `src_from_reg`=0 and register `src_sel` when it is 1. A request with `wr_en`=1 writes the chain result into register `wr_sel`. Register reads in a cycle see the contents from before that cycle's write. Other registers are unchanged.
- R11: `wr_en` has no effect in a cycle where `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request in this cycle |
| mem_vec | input | NBYTES*8 | Vector arriving from memory |
| src_from_reg | input | 1 | Take chain source from a register |
| src_sel | input | log2(NREGS) | Source register |
| op_a | input | 3 | First slot opcode |
| op_b | input | 3 | Second slot opcode |
| op_c | input | 3 | Third slot opcode |
| rot_amt | input | log2(MAXROT+1) | Rotation in bytes |
| bcast_idx | input | log2(NBYTES) | Byte lane copied by broadcast |
| blend_sel | input | log2(NREGS) | Register supplying merge bytes |
| mask_sel | input | log2(NREGS) | Register supplying merge mask |
| wr_en | input | 1 | Write chain result to a register |
| wr_sel | input | log2(NREGS) | Destination register |
| res_vec | output | NBYTES*8 | Registered chain result |
| res_valid | output | 1 | res_vec holds a new result |

## Verification
Some properties are checked by assertions in every cycle. These are the valid handshake and the hold of the output when idle. They also cover the equal-byte shape of any broadcast slot output and the zeroed upper part of a pooling slot output. Last, each register must stay untouched when it is not addressed by an enabled write. The byte arithmetic itself can only be shown by the directed scenarios, which compare against a model built from the requirements. That arithmetic includes rotation wrap and the 64-byte limit, signed maxima with negative bytes, and mask selection. The scenarios also cover the slot order in a chain and read-before-write in the register file.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ROT   = 3'd1,
    OP_BCAST = 3'd2,
    OP_POOL2 = 3'd3,
    OP_POOL4 = 3'd4,
    OP_SWAP  = 3'd5,
    OP_MERGE = 3'd6,
    OP_RSVD  = 3'd7
  } vp_op_e;

  localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/vperm_stage.sv
module vperm_stage
  import vperm_pkg::*;
#(
  parameter int NBYTES = 128,
  parameter int MAXROT = 64,
  localparam int BW    = NBYTES * 8,
  localparam int ROTW  = $clog2(MAXROT + 1),
  localparam int IDXW  = $clog2(NBYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op,
  input  logic [ROTW-1:0] rot_amt,
  input  logic [IDXW-1:0] bcast_idx,
  input  logic [BW-1:0]   din,
  input  logic [BW-1:0]   blend_vec,
  input  logic [BW-1:0]   mask_vec,
  output logic [BW-1:0]   dout
);
  logic [ROTW-1:0] rot_eff;
  logic [2*BW-1:0] rot_wide;
  logic [BW-1:0]   rot_res, bc_res, p2_res, p4_res, sw_res, mg_res;
  logic [7:0]      bc_byte;

  always_comb begin
    rot_eff  = (rot_amt > ROTW'(MAXROT)) ? ROTW'(MAXROT) : rot_amt;
    rot_wide = {din, din} >> {rot_eff, 3'b000};
    rot_res  = rot_wide[BW-1:0];
  end

  always_comb begin
    bc_byte = din[bcast_idx*8 +: 8];
    bc_res  = {NBYTES{bc_byte}};
  end

  always_comb begin
    logic signed [7:0] m;
    p2_res = '0;
    p4_res = '0;
    for (int j = 0; j < NBYTES/2; j++) begin
      m = din[(2*j)*8 +: 8];
      if ($signed(din[(2*j+1)*8 +: 8]) > m) m = din[(2*j+1)*8 +: 8];
      p2_res[j*8 +: 8] = m;
    end
    for (int j = 0; j < NBYTES/4; j++) begin
      m = din[(4*j)*8 +: 8];
      for (int k = 1; k < 4; k++)
        if ($signed(din[(4*j+k)*8 +: 8]) > m) m = din[(4*j+k)*8 +: 8];
      p4_res[j*8 +: 8] = m;
    end
  end

  always_comb begin
    for (int k = 0; k < NBYTES/2; k++) begin
      sw_res[(2*k)*8 +: 8]   = din[(2*k+1)*8 +: 8];
      sw_res[(2*k+1)*8 +: 8] = din[(2*k)*8 +: 8];
    end
  end

  always_comb begin
    for (int i = 0; i < NBYTES; i++)
      mg_res[i*8 +: 8] = mask_vec[i*8] ? blend_vec[i*8 +: 8] : din[i*8 +: 8];
  end

  always_comb begin
    case (vp_op_e'(op))
      OP_ROT:   dout = rot_res;
      OP_BCAST: dout = bc_res;
      OP_POOL2: dout = p2_res;
      OP_POOL4: dout = p4_res;
      OP_SWAP:  dout = sw_res;
      OP_MERGE: dout = mg_res;
      default:  dout = din;
    endcase
  end

  // R4
  bcast_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BCAST) |-> (dout == {NBYTES{dout[7:0]}}));

  // R5
  pool2_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POOL2) |-> (dout[BW-1:BW/2] == '0));

  // R6
  pool4_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POOL4) |-> (dout[BW-1:BW/4] == '0));
endmodule

// File: rtl/vperm_regfile.sv
module vperm_regfile #(
  parameter int NBYTES = 128,
  parameter int NREGS  = 4,
  localparam int BW    = NBYTES * 8,
  localparam int SELW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SELW-1:0] wsel,
  input  logic [BW-1:0]   wdata,
  input  logic [SELW-1:0] rsel_src,
  input  logic [SELW-1:0] rsel_blend,
  input  logic [SELW-1:0] rsel_mask,
  output logic [BW-1:0]   rd_src,
  output logic [BW-1:0]   rd_blend,
  output logic [BW-1:0]   rd_mask
);
  logic [BW-1:0] regs_q [NREGS];

  assign rd_src   = regs_q[rsel_src];
  assign rd_blend = regs_q[rsel_blend];
  assign rd_mask  = regs_q[rsel_mask];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic          en;
    logic [BW-1:0] d;

    always_comb begin
      en = we && (wsel == SELW'(r));
      d  = en ? wdata : regs_q[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[r] <= '0;
      else if (en) regs_q[r] <= d;
    end

    // R10
    reg_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (wsel == SELW'(r))) |=> $stable(regs_q[r]));
  end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int NBYTES = 128,
  parameter int NREGS  = 4,
  parameter int MAXROT = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [NBYTES*8-1:0]          mem_vec,
  input  logic                         src_from_reg,
  input  logic [$clog2(NREGS)-1:0]     src_sel,
  input  logic [2:0]                   op_a,
  input  logic [2:0]                   op_b,
  input  logic [2:0]                   op_c,
  input  logic [$clog2(MAXROT+1)-1:0]  rot_amt,
  input  logic [$clog2(NBYTES)-1:0]    bcast_idx,
  input  logic [$clog2(NREGS)-1:0]     blend_sel,
  input  logic [$clog2(NREGS)-1:0]     mask_sel,
  input  logic                         wr_en,
  input  logic [$clog2(NREGS)-1:0]     wr_sel,
  output logic [NBYTES*8-1:0]          res_vec,
  output logic                         res_valid
);
  localparam int BW = NBYTES * 8;

  logic [BW-1:0] rd_src, rd_blend, rd_mask;
  logic [BW-1:0] chain [NUM_SLOTS+1];
  logic [2:0]    slot_op [NUM_SLOTS];
  logic [BW-1:0] res_d, res_q;
  logic          vld_d, vld_q;
  logic          rf_we;

  assign slot_op[0] = op_a;
  assign slot_op[1] = op_b;
  assign slot_op[2] = op_c;
  assign rf_we      = req_valid && wr_en;
  assign chain[0]   = src_from_reg ? rd_src : mem_vec;

  vperm_regfile #(.NBYTES(NBYTES), .NREGS(NREGS)) rf_i (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wsel(wr_sel), .wdata(chain[NUM_SLOTS]),
    .rsel_src(src_sel), .rsel_blend(blend_sel), .rsel_mask(mask_sel),
    .rd_src(rd_src), .rd_blend(rd_blend), .rd_mask(rd_mask)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    vperm_stage #(.NBYTES(NBYTES), .MAXROT(MAXROT)) stage_i (
      .clk(clk), .rst_n(rst_n), .op(slot_op[s]), .rot_amt(rot_amt),
      .bcast_idx(bcast_idx), .din(chain[s]), .blend_vec(rd_blend),
      .mask_vec(rd_mask), .dout(chain[s+1])
    );
  end

  always_comb begin
    vld_d = req_valid;
    res_d = req_valid ? chain[NUM_SLOTS] : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (req_valid) res_q <= res_d;
    end
  end

  assign res_vec   = res_q;
  assign res_valid = vld_q;

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_vec));
endmodule

// File: tb/vperm_unit_tb_top.sv
module vperm_unit_tb_top;
  localparam int NB = 128;
  localparam int BW = NB * 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, src_from_reg, wr_en;
  logic [BW-1:0] mem_vec;
  logic [1:0] src_sel, blend_sel, mask_sel, wr_sel;
  logic [2:0] op_a, op_b, op_c;
  logic [6:0] rot_amt;
  logic [6:0] bcast_idx;
  logic [BW-1:0] res_vec;
  logic res_valid;

  int checks = 0;
  int errors = 0;
  logic [BW-1:0] mregs [4];

  always #10 clk = ~clk;

  vperm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_vec(mem_vec),
    .src_from_reg(src_from_reg), .src_sel(src_sel), .op_a(op_a), .op_b(op_b),
    .op_c(op_c), .rot_amt(rot_amt), .bcast_idx(bcast_idx), .blend_sel(blend_sel),
    .mask_sel(mask_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .res_vec(res_vec), .res_valid(res_valid)
  );

  function automatic logic [BW-1:0] pat(int seed);
    logic [BW-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = 8'(i * seed + seed * 3 + 1);
    return v;
  endfunction

  function automatic logic [BW-1:0] model_op(logic [2:0] op, logic [BW-1:0] v,
      int amt, int idx, logic [BW-1:0] bl, logic [BW-1:0] mk);
    logic [BW-1:0] o;
    logic signed [7:0] m;
    int a;
    o = v;
    a = (amt > 64) ? 64 : amt;
    case (op)
      3'd1: for (int i = 0; i < NB; i++) o[i*8 +: 8] = v[((i + a) % NB)*8 +: 8];
      3'd2: for (int i = 0; i < NB; i++) o[i*8 +: 8] = v[idx*8 +: 8];
      3'd3, 3'd4: begin
        int g;
        g = (op == 3'd3) ? 2 : 4;
        o = '0;
        for (int j = 0; j < NB/g; j++) begin
          m = v[(g*j)*8 +: 8];
          for (int k = 1; k < g; k++)
            if ($signed(v[(g*j+k)*8 +: 8]) > m) m = v[(g*j+k)*8 +: 8];
          o[j*8 +: 8] = m;
        end
      end
      3'd5: for (int i = 0; i < NB; i++) o[i*8 +: 8] = v[(i ^ 1)*8 +: 8];
      3'd6: for (int i = 0; i < NB; i++) o[i*8 +: 8] = mk[i*8] ? bl[i*8 +: 8] : v[i*8 +: 8];
      default: o = v;
    endcase
    return o;
  endfunction

  task automatic chk(string req, string what, logic [BW-1:0] got, logic [BW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic issue(string req, logic [2:0] a, logic [2:0] b, logic [2:0] c,
      int amt, int idx, logic sreg, int s, int bl, int mk, logic we, int w,
      logic [BW-1:0] mem);
    logic [BW-1:0] exp;
    exp = sreg ? mregs[s] : mem;
    exp = model_op(a, exp, amt, idx, mregs[bl], mregs[mk]);
    exp = model_op(b, exp, amt, idx, mregs[bl], mregs[mk]);
    exp = model_op(c, exp, amt, idx, mregs[bl], mregs[mk]);
    @(negedge clk);
    req_valid = 1'b1; op_a = a; op_b = b; op_c = c;
    rot_amt = 7'(amt); bcast_idx = 7'(idx); src_from_reg = sreg;
    src_sel = 2'(s); blend_sel = 2'(bl); mask_sel = 2'(mk);
    wr_en = we; wr_sel = 2'(w); mem_vec = mem;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    if (we) mregs[w] = exp;
    chk(req, "result", res_vec, exp);
    chk("R2", "valid after request", {{(BW-1){1'b0}}, res_valid}, {{(BW-1){1'b0}}, 1'b1});
  endtask

  task automatic read_reg(string req, int r);
    issue(req, 3'd0, 3'd0, 3'd0, 0, 0, 1'b1, r, 0, 0, 1'b0, 0, '0);
  endtask

  task automatic t_reset;
    chk("R1", "res_vec in reset", res_vec, '0);
    chk("R1", "res_valid in reset", {{(BW-1){1'b0}}, res_valid}, '0);
    for (int r = 0; r < 4; r++) read_reg("R1", r);
  endtask

  task automatic t_rotate;
    issue("R3", 3'd1, 3'd0, 3'd0, 0,   0, 1'b0, 0, 0, 0, 1'b0, 0, pat(7));
    issue("R3", 3'd1, 3'd0, 3'd0, 1,   0, 1'b0, 0, 0, 0, 1'b0, 0, pat(7));
    issue("R3", 3'd1, 3'd0, 3'd0, 37,  0, 1'b0, 0, 0, 0, 1'b0, 0, pat(11));
    issue("R3", 3'd1, 3'd0, 3'd0, 64,  0, 1'b0, 0, 0, 0, 1'b0, 0, pat(13));
    issue("R3", 3'd1, 3'd0, 3'd0, 100, 0, 1'b0, 0, 0, 0, 1'b0, 0, pat(13));
  endtask

  task automatic t_broadcast;
    issue("R4", 3'd2, 3'd0, 3'd0, 0, 0,   1'b0, 0, 0, 0, 1'b0, 0, pat(5));
    issue("R4", 3'd2, 3'd0, 3'd0, 0, 127, 1'b0, 0, 0, 0, 1'b0, 0, pat(9));
  endtask

  task automatic t_pool;
    issue("R5", 3'd3, 3'd0, 3'd0, 0, 0, 1'b0, 0, 0, 0, 1'b0, 0, pat(37));
    issue("R5", 3'd3, 3'd0, 3'd0, 0, 0, 1'b0, 0, 0, 0, 1'b0, 0, {NB{8'h80}});
    issue("R6", 3'd4, 3'd0, 3'd0, 0, 0, 1'b0, 0, 0, 0, 1'b0, 0, pat(53));
    issue("R6", 3'd4, 3'd0, 3'd0, 0, 0, 1'b0, 0, 0, 0, 1'b0, 0, {(NB/2){16'hFF7F}});
  endtask

  task automatic t_swap;
    issue("R7", 3'd5, 3'd0, 3'd0, 0, 0, 1'b0, 0, 0, 0, 1'b0, 0, pat(3));
  endtask

  task automatic t_merge;
    issue("R10", 3'd0, 3'd0, 3'd0, 0, 0, 1'b0, 0, 0, 0, 1'b1, 1, pat(17));
    issue("R10", 3'd0, 3'd0, 3'd0, 0, 0, 1'b0, 0, 0, 0, 1'b1, 2, pat(29));
    read_reg("R10", 1);
    read_reg("R10", 2);
    read_reg("R10", 0);
    issue("R8", 3'd6, 3'd0, 3'd0, 0, 0, 1'b0, 0, 1, 2, 1'b0, 0, pat(41));
    issue("R8", 3'd6, 3'd0, 3'd0, 0, 0, 1'b0, 0, 1, 0, 1'b0, 0, pat(41));
  endtask

  task automatic t_chain;
    issue("R9", 3'd1, 3'd5, 3'd3, 5,  0,  1'b0, 0, 0, 0, 1'b0, 0, pat(23));
    issue("R9", 3'd5, 3'd2, 3'd0, 0,  10, 1'b0, 0, 0, 0, 1'b0, 0, pat(19));
    issue("R9", 3'd2, 3'd5, 3'd0, 0,  10, 1'b0, 0, 0, 0, 1'b0, 0, pat(19));
    issue("R9", 3'd7, 3'd0, 3'd7, 0,  0,  1'b0, 0, 0, 0, 1'b0, 0, pat(31));
    issue("R9", 3'd6, 3'd1, 3'd4, 64, 0,  1'b0, 0, 1, 2, 1'b0, 0, pat(43));
  endtask

  task automatic t_reg_rw;
    issue("R10", 3'd1, 3'd0, 3'd0, 1, 0, 1'b1, 1, 0, 0, 1'b1, 1, '0);
    read_reg("R10", 1);
    issue("R10", 3'd5, 3'd0, 3'd0, 0, 0, 1'b1, 2, 0, 0, 1'b1, 3, pat(61));
    read_reg("R10", 3);
    read_reg("R10", 2);
  endtask

  task automatic t_idle;
    logic [BW-1:0] held;
    held = res_vec;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; mem_vec = pat(99); src_from_reg = 1'b0;
    op_a = 3'd0; op_b = 3'd0; op_c = 3'd0;
    @(negedge clk);
    chk("R2", "held while idle", res_vec, held);
    chk("R2", "valid low while idle", {{(BW-1){1'b0}}, res_valid}, '0);
    wr_en = 1'b0;
    read_reg("R11", 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; wr_en = 1'b0; src_from_reg = 1'b0;
    mem_vec = '0; src_sel = '0; blend_sel = '0; mask_sel = '0; wr_sel = '0;
    op_a = '0; op_b = '0; op_c = '0; rot_amt = '0; bcast_idx = '0;
    for (int r = 0; r < 4; r++) mregs[r] = '0;
    repeat (3) @(negedge clk);
    t_reset_in: begin
      chk("R1", "res_vec during reset", res_vec, '0);
    end
    rst_n = 1'b1;
    t_reset;
    t_rotate;
    t_broadcast;
    t_pool;
    t_swap;
    t_merge;
    t_chain;
    t_reg_rw;
    t_idle;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule